// File: doc/BRIEF.md
# Slave-Port Arbiter with Default-Master Parking

This unit sits in front of one slave port of a multi-master interconnect. Up to eight masters raise request lines toward the slave, and the unit grants exactly one of them at a time through a one-hot grant vector. A master performs an access on every clock edge at which its request and its grant are both high. It holds its request for the length of its burst and drops it when the burst is done. When several masters wait, the next grant rotates round-robin, starting after the master that was served most recently.

A programmable slot limit stops a long burst from locking the slave. Once the granted master has completed the programmed number of access cycles and another master is waiting, the grant moves on. If nobody else is waiting, the burst keeps the slave. A limit of zero disables the cut-off.

When the slave goes idle, a parking policy decides where the grant rests. It can rest on no master, on the last master that accessed the slave, or on a fixed master chosen in the configuration. A master that finds the grant already parked on itself is served on the same edge at which it raises its request. Any other master waits one extra cycle. A single 32-bit configuration word holds the slot limit, the parking policy and the fixed master number. Writes to it are refused while the write-protect input is high.

Top module: `slv_port_arb`

## Requirements
- R1: At most one bit of `gnt` is high in any cycle, and `gnt` is all zero during and directly after reset.
- R2: When the slave is free and several masters request, the grant goes to the first requester found by scanning upward, with wrap-around, starting just after the master that last performed an access (or after the highest index if none has). A grant that is preempted moves to the next waiting master after the current owner, in the same order.
- R3: With a slot limit L > 0, a granted master that keeps requesting while another master requests loses the grant on the edge of its L-th access cycle. The grant moves to a waiting master on that same edge.
- R4: A master that is the only requester keeps its grant however long its burst lasts. With L = 0, a requesting owner is never preempted.
- R5: Parking type 0 (field value 0): when the owner stops requesting and nobody else requests, `gnt` drops to zero. A later request is granted on the edge after it is raised. The fixed-master field has no effect under this type.
- R6: Parking type 1 (field value 1): with no requests, the grant rests on the master that performed the most recent access. That master sees its grant already high when it raises its request.
- R7: Parking type 2 (field value 2): with no requests, the grant rests on the master numbered in the fixed-master field, provided that master's bit in `conn_mask` is set. Another master that requests still wins the slave on the next edge.
- R8: Under type 2, a fixed master outside the connected set, or one numbered at or above the master count, makes the unit behave as type 0. The reserved type value 3 also behaves as type 0.
- R9: Configuration word layout: slot limit in bits [7:0], parking type in bits [17:16], fixed master number in bits [20:18]. All other bits read as zero. The reset value is 0x00000010 (limit 16, type 0, fixed master 0).
- R10: A write while `wp_en` is high leaves the configuration word unchanged. A write while `wp_en` is low updates it on that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_MST | Request line from each master |
| conn_mask | input | N_MST | Set bit marks a master that can reach this slave |
| gnt | output | N_MST | One-hot grant, zero when the slave is not connected |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| wp_en | input | 1 | Write protect; blocks configuration writes while high |
| cfg_rdata | output | 32 | Current configuration word |

## Verification
The hardest case to reach is a slot preemption that lands on an exact edge. It only happens when one master has held a burst for precisely the programmed number of access cycles while a second master has been waiting the whole time. The stimulus first gives the slave to one master alone, so the count starts from a known grant edge. It then raises a competing request and holds both for the full window, and expects the handoff on one specific edge. The same run is repeated in the opposite direction. A limit of one then turns this into a per-cycle rotation, which exposes the round-robin order directly. Parking to a fixed master that is not connected is reached by first parking on it while it is connected, then clearing its connectivity bit in the same cycle as an idle edge.

// File: rtl/slv_arb_pkg.sv
package slv_arb_pkg;

    localparam int SLOT_W  = 8;
    localparam int FIXED_W = 3;

    typedef enum logic [1:0] {
        PARK_NONE  = 2'd0,
        PARK_LAST  = 2'd1,
        PARK_FIXED = 2'd2,
        PARK_RSVD  = 2'd3
    } park_t;

    typedef struct packed {
        logic [SLOT_W-1:0]  slot;
        park_t              ptype;
        logic [FIXED_W-1:0] fixed;
    } arb_cfg_t;

    localparam logic [SLOT_W-1:0] SLOT_RST = 8'd16;

endpackage

// File: rtl/slv_arb_cfg.sv
module slv_arb_cfg
    import slv_arb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    input  logic        wp_en,
    output arb_cfg_t    cfg,
    output logic [31:0] rdata
);

    arb_cfg_t cfg_d, cfg_q;
    logic     wr_unused;

    assign wr_unused = ^{wdata[31:21], wdata[15:8]};

    always_comb begin
        cfg_d = cfg_q;
        if (we && !wp_en) begin
            cfg_d.slot  = wdata[7:0];
            cfg_d.ptype = park_t'(wdata[17:16]);
            cfg_d.fixed = wdata[20:18];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.slot  <= SLOT_RST;
            cfg_q.ptype <= PARK_NONE;
            cfg_q.fixed <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg   = cfg_q;
    assign rdata = {11'd0, cfg_q.fixed, cfg_q.ptype, 8'd0, cfg_q.slot};

endmodule

// File: rtl/slv_arb_rr.sv
module slv_arb_rr #(
    parameter int N_MST = 8,
    parameter int MID_W = 3
) (
    input  logic [N_MST-1:0] vec,
    input  logic [MID_W-1:0] ptr,
    output logic             found,
    output logic [MID_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_MST; i >= 1; i--) begin
            int j;
            j = (int'(ptr) + i) % N_MST;
            if (vec[j]) begin
                found = 1'b1;
                idx   = MID_W'(j);
            end
        end
    end

endmodule

// File: rtl/slv_arb_park.sv
module slv_arb_park
    import slv_arb_pkg::*;
#(
    parameter int N_MST = 8,
    parameter int MID_W = 3
) (
    input  park_t              ptype,
    input  logic [FIXED_W-1:0] fixed,
    input  logic [N_MST-1:0]   conn_mask,
    input  logic               last_vld,
    input  logic [MID_W-1:0]   last_id,
    output logic               park_vld,
    output logic [MID_W-1:0]   park_id
);

    logic [N_MST-1:0] fixed_hit;
    logic             fixed_conn;

    genvar g;
    generate
        for (g = 0; g < N_MST; g++) begin : g_fix
            assign fixed_hit[g] = (int'(fixed) == g) && conn_mask[g];
        end
    endgenerate

    assign fixed_conn = |fixed_hit;

    always_comb begin
        park_vld = 1'b0;
        park_id  = '0;
        case (ptype)
            PARK_LAST: begin
                park_vld = last_vld;
                park_id  = last_id;
            end
            PARK_FIXED: begin
                park_vld = fixed_conn;
                park_id  = MID_W'(fixed);
            end
            default: begin
                park_vld = 1'b0;
                park_id  = '0;
            end
        endcase
    end

endmodule

// File: rtl/slv_port_arb.sv
module slv_port_arb
    import slv_arb_pkg::*;
#(
    parameter int N_MST = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MST-1:0] req,
    input  logic [N_MST-1:0] conn_mask,
    output logic [N_MST-1:0] gnt,
    input  logic             cfg_we,
    input  logic [31:0]      cfg_wdata,
    input  logic             wp_en,
    output logic [31:0]      cfg_rdata
);

    localparam int MID_W = (N_MST > 1) ? $clog2(N_MST) : 1;

    typedef struct packed {
        logic              owned;
        logic [MID_W-1:0]  owner;
        logic              last_vld;
        logic [MID_W-1:0]  last;
        logic [SLOT_W-1:0] cnt;
    } arb_st_t;

    arb_st_t          st_d, st_q;
    arb_cfg_t         cfg;
    logic [N_MST-1:0] owner_hot;
    logic             owner_req;
    logic [N_MST-1:0] pick_vec;
    logic [MID_W-1:0] pick_ptr;
    logic             pick_found;
    logic [MID_W-1:0] pick_id;
    logic             park_vld;
    logic [MID_W-1:0] park_id;
    logic [SLOT_W-1:0] cnt_inc;
    logic             limit_hit;

    slv_arb_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .wp_en (wp_en),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    slv_arb_rr #(.N_MST(N_MST), .MID_W(MID_W)) u_rr (
        .vec   (pick_vec),
        .ptr   (pick_ptr),
        .found (pick_found),
        .idx   (pick_id)
    );

    slv_arb_park #(.N_MST(N_MST), .MID_W(MID_W)) u_park (
        .ptype     (cfg.ptype),
        .fixed     (cfg.fixed),
        .conn_mask (conn_mask),
        .last_vld  (st_q.last_vld),
        .last_id   (st_q.last),
        .park_vld  (park_vld),
        .park_id   (park_id)
    );

    assign owner_hot = st_q.owned ? (N_MST'(1) << st_q.owner) : '0;
    assign owner_req = |(owner_hot & req);
    assign cnt_inc   = (&st_q.cnt) ? st_q.cnt : st_q.cnt + 1'b1;
    assign limit_hit = (cfg.slot != '0) && (cnt_inc >= cfg.slot);

    always_comb begin
        if (owner_req) begin
            pick_vec = req & ~owner_hot;
            pick_ptr = st_q.owner;
        end else begin
            pick_vec = req;
            pick_ptr = st_q.last_vld ? st_q.last : MID_W'(N_MST - 1);
        end
    end

    always_comb begin
        st_d = st_q;
        if (owner_req) begin
            st_d.last     = st_q.owner;
            st_d.last_vld = 1'b1;
            if (limit_hit && pick_found) begin
                st_d.owner = pick_id;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt   = cnt_inc;
            end
        end else if (pick_found) begin
            st_d.owned = 1'b1;
            st_d.owner = pick_id;
            st_d.cnt   = '0;
        end else begin
            st_d.owned = park_vld;
            st_d.owner = park_vld ? park_id : st_q.owner;
            st_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt = owner_hot;

endmodule

// File: rtl/slv_port_arb_chk.sv
module slv_port_arb_chk #(
    parameter int N_MST = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_MST-1:0] req,
    input logic [N_MST-1:0] conn_mask,
    input logic [N_MST-1:0] gnt,
    input logic             cfg_we,
    input logic             wp_en,
    input logic [31:0]      cfg_rdata
);

    logic [1:0] ptype;
    logic [2:0] fixed;
    logic [7:0] slot;
    logic       fixed_conn;

    assign ptype = cfg_rdata[17:16];
    assign fixed = cfg_rdata[20:18];
    assign slot  = cfg_rdata[7:0];

    always_comb begin
        fixed_conn = 1'b0;
        for (int i = 0; i < N_MST; i++) begin
            if (int'(fixed) == i && conn_mask[i]) fixed_conn = 1'b1;
        end
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R1

    AST_ALONE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt & req) != '0 && (req & ~gnt) == '0) |=> (gnt == $past(gnt))); // R4

    AST_NO_LIMIT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == 8'd0 && (gnt & req) != '0) |=> (gnt == $past(gnt))); // R4

    AST_TYPE0_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0 && (ptype == 2'd0 || ptype == 2'd3)) |=> (gnt == '0)); // R5

    AST_TYPE1_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0 && ptype == 2'd1 && gnt != '0 && $past(req) == '0 && $past(ptype) == 2'd1)
        |=> $stable(gnt)); // R6

    AST_UNCONN_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0 && ptype == 2'd2 && !fixed_conn) |=> (gnt == '0)); // R8

    AST_WP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && wp_en) |=> $stable(cfg_rdata)); // R10

endmodule

bind slv_port_arb slv_port_arb_chk #(.N_MST(N_MST)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .conn_mask (conn_mask),
    .gnt       (gnt),
    .cfg_we    (cfg_we),
    .wp_en     (wp_en),
    .cfg_rdata (cfg_rdata)
);

// File: tb/sim_slv_port_arb.sv
`timescale 1ns/1ps
module sim_slv_port_arb;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] conn_mask = '1;
    logic [N-1:0] gnt;
    logic         cfg_we = 1'b0;
    logic [31:0]  cfg_wdata = '0;
    logic         wp_en = 1'b0;
    logic [31:0]  cfg_rdata;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [N-1:0] exp;
        string        tag;
    } exp_t;

    exp_t sb_q[$];

    always #10 clk = ~clk;

    slv_port_arb #(.N_MST(N)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .conn_mask (conn_mask),
        .gnt       (gnt),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .wp_en     (wp_en),
        .cfg_rdata (cfg_rdata)
    );

    function automatic logic [31:0] cw(input logic [7:0] s, input logic [1:0] t, input logic [2:0] f);
        return {11'd0, f, t, 8'd0, s};
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // driver: one cycle of stimulus, expected grant after the next edge
    task automatic step(input logic [N-1:0] r, input logic [N-1:0] e, input string tag,
                        input logic [N-1:0] m = '1);
        @(negedge clk);
        req       = r;
        conn_mask = m;
        sb_q.push_back('{exp: e, tag: tag});
    endtask

    task automatic cfg_write(input logic [31:0] d, input logic [31:0] e, input string tag);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = d;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        chk(cfg_rdata, e, tag);
    endtask

    // monitor: compares one expected item per cycle, mid high phase
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                chk({24'd0, gnt}, {24'd0, it.exp}, it.tag);
                chk(32'($countones(gnt) <= 1), 32'd1, "R1");
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({24'd0, gnt}, 32'd0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk({24'd0, gnt}, 32'd0, "R1");
        chk(cfg_rdata, 32'h0000_0010, "R9");

        // type 0: no parking, one cycle latency
        step(8'h00, 8'h00, "R5");
        step(8'h01, 8'h01, "R5");
        step(8'h01, 8'h01, "R5");
        step(8'h00, 8'h00, "R5");
        step(8'h00, 8'h00, "R5");
        step(8'h01, 8'h01, "R5");
        step(8'h00, 8'h00, "R5");

        // type 1: rest on last accessor
        cfg_write(cw(8'd16, 2'd1, 3'd0), cw(8'd16, 2'd1, 3'd0), "R9");
        step(8'h04, 8'h04, "R6");
        step(8'h04, 8'h04, "R6");
        step(8'h00, 8'h04, "R6");
        step(8'h00, 8'h04, "R6");
        step(8'h04, 8'h04, "R6");
        step(8'h00, 8'h04, "R6");

        // type 2: rest on fixed master 5
        cfg_write(cw(8'd16, 2'd2, 3'd5), cw(8'd16, 2'd2, 3'd5), "R9");
        step(8'h00, 8'h20, "R7");
        step(8'h20, 8'h20, "R7");
        step(8'h00, 8'h20, "R7");
        step(8'h08, 8'h08, "R7");
        step(8'h08, 8'h08, "R7");
        step(8'h00, 8'h20, "R7");

        // fixed master loses connectivity
        cfg_write(cw(8'd16, 2'd2, 3'd6), cw(8'd16, 2'd2, 3'd6), "R9");
        step(8'h00, 8'h40, "R7");
        step(8'h00, 8'h00, "R8", 8'hBF);
        step(8'h00, 8'h40, "R7");
        // reserved type acts as type 0
        cfg_write(cw(8'd16, 2'd3, 3'd6), cw(8'd16, 2'd3, 3'd6), "R9");
        step(8'h00, 8'h00, "R8");
        step(8'h00, 8'h00, "R8");
        // fixed field ignored under type 0
        cfg_write(cw(8'd16, 2'd0, 3'd5), cw(8'd16, 2'd0, 3'd5), "R9");
        step(8'h00, 8'h00, "R5");

        // slot limit 4: preempt on the 4th access cycle, both ways
        cfg_write(cw(8'd4, 2'd0, 3'd0), cw(8'd4, 2'd0, 3'd0), "R9");
        step(8'h01, 8'h01, "R3");
        step(8'h03, 8'h01, "R3");
        step(8'h03, 8'h01, "R3");
        step(8'h03, 8'h01, "R3");
        step(8'h03, 8'h02, "R3");
        step(8'h03, 8'h02, "R3");
        step(8'h03, 8'h02, "R3");
        step(8'h03, 8'h02, "R3");
        step(8'h03, 8'h01, "R3");
        step(8'h00, 8'h00, "R5");

        // lone requester never preempted
        cfg_write(cw(8'd2, 2'd0, 3'd0), cw(8'd2, 2'd0, 3'd0), "R9");
        step(8'h02, 8'h02, "R4");
        for (int i = 0; i < 6; i++) step(8'h02, 8'h02, "R4");
        step(8'h00, 8'h00, "R4");

        // limit 0: no cut-off even with a waiting master
        cfg_write(cw(8'd0, 2'd0, 3'd0), cw(8'd0, 2'd0, 3'd0), "R9");
        step(8'h01, 8'h01, "R4");
        for (int i = 0; i < 10; i++) step(8'h03, 8'h01, "R4");
        step(8'h02, 8'h02, "R2");
        step(8'h00, 8'h00, "R5");

        // round-robin rotation with limit 1
        cfg_write(cw(8'd1, 2'd0, 3'd0), cw(8'd1, 2'd0, 3'd0), "R9");
        step(8'h80, 8'h80, "R2");
        step(8'h80, 8'h80, "R2");
        step(8'h00, 8'h00, "R2");
        step(8'h29, 8'h01, "R2");
        step(8'h29, 8'h08, "R2");
        step(8'h29, 8'h20, "R2");
        step(8'h29, 8'h01, "R2");
        step(8'h29, 8'h08, "R2");
        step(8'h00, 8'h00, "R2");

        // register layout and write protect
        while (sb_q.size() > 0) @(negedge clk);
        cfg_write(32'hFFFF_FFFF, 32'h001F_00FF, "R9");
        wp_en = 1'b1;
        cfg_write(32'h0000_0000, 32'h001F_00FF, "R10");
        cfg_write(cw(8'd7, 2'd1, 3'd2), 32'h001F_00FF, "R10");
        wp_en = 1'b0;
        cfg_write(cw(8'd16, 2'd0, 3'd0), 32'h0000_0010, "R10");

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule